// File: doc/BRIEF.md
# Wired and Doorbell Interrupt Collector

This block gathers 64 interrupt sources into one upstream interrupt line. Sources 0 to 20 arrive as wires from neighbouring logic. The block sets their cause bit on a rising edge of the wire. Sources 21 to 63 have no wire. A requester raises one of them by writing the source number to a single doorbell register. Every source owns one bit in a 64-bit cause vector and one bit in a 64-bit mask vector. The upstream line is high while any cause bit is set and its mask bit is clear.

Software reaches the block over a small 32-bit register bus. It reads the raw cause words to find pending sources, because the block does no priority selection. It changes the mask words to block or enable sources. To acknowledge a source, it writes the bit position of that source into the cause word that holds it. This clears only that one bit, so acknowledging one source cannot disturb the others.

The bus carries control traffic only, so it has no back-pressure. A request is a single cycle with valid high. The block accepts every request in the cycle it is presented. Read data comes back exactly one cycle later, marked by a read-valid pulse.

Top module: `irq_collector`

## Requirements
- R1: After reset every cause bit is 0, every mask bit is 1 and `irq_o` is low.
- R2: A 0-to-1 transition on `wired_i[i]` (i in 0..20) sets cause bit i in the clock edge at which the high level is first sampled. A wire held high does not set the bit again after it has been acknowledged.
- R3: A write to byte offset 0x30 whose full 32-bit data value d lies in 21..63 sets cause bit d. A doorbell write with any other data value changes no cause bit.
- R4: A read returns its data on `bus_rdata` one cycle after the request, with `bus_rvalid` high in that cycle. Offset 0x00 gives cause bits 31..0 and offset 0x04 gives cause bits 63..32. Offsets 0x20 and 0x24 give the mask bits in the same layout. Source i sits in word i/32 at bit i mod 32.
- R5: A write of data d < 32 to offset 0x00 clears cause bit d. The same write to offset 0x04 clears cause bit 32+d. No other bit changes. A write of d >= 32 to either cause word changes nothing.
- R6: A write to offset 0x20 or 0x24 replaces that whole mask word. A mask bit of 1 keeps its source off `irq_o`, and a mask bit of 0 lets it through.
- R7: `irq_o` is a register holding the OR over all sources of (cause AND NOT mask). It reflects a cause or mask update one clock after the update.
- R8: When a wired rising edge and an acknowledge hit the same cause bit in the same cycle, the bit ends up set.
- R9: Reads of any offset other than 0x00, 0x04, 0x20 and 0x24 return zero, and that includes the doorbell offset and unaligned offsets. Writes to offsets other than those four and 0x30 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wired_i | input | 21 | Wired interrupt inputs, sources 0..20, synchronous to clk |
| bus_valid | input | 1 | Register request valid for one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | High in the cycle `bus_rdata` holds read data |
| irq_o | output | 1 | Combined upstream interrupt |

## Verification
A cause bit that is set or cleared wrongly shows up on two paths. It appears in the next read of its cause word. When the source is unmasked, it also moves `irq_o` exactly one cycle after the faulty update. A mask bit that is stuck or decoded onto the wrong source shows up as `irq_o` staying high or low in the cycle after a mask write. A decode that hits the wrong index during a doorbell write or an acknowledge leaves a stray bit in the cause words. The read-back after every single-source operation exposes that bit within two cycles.

// File: rtl/irq_col_pkg.sv
package irq_col_pkg;
  localparam int CAUSE_BASE   = 'h00;
  localparam int MASK_BASE    = 'h20;
  localparam int DOORBELL_OFS = 'h30;
  localparam int WORD_STRIDE  = 4;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int N = 21
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] pulse_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~prev_q;

  // R2: a held level never yields pulses on two consecutive cycles
  assert_no_repeat_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (pulse_o & $past(pulse_o)) == '0);
endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode #(
  parameter int NUM_SRC   = 64,
  parameter int NUM_WIRED = 21,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_valid,
  input  logic                           bus_write,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [NUM_SRC-1:0]             db_set,
  output logic [NUM_SRC-1:0]             ack_clr,
  output logic [NUM_SRC/DATA_W-1:0]      mask_we
);
  import irq_col_pkg::*;
  localparam int NUM_WORDS = NUM_SRC / DATA_W;
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int BIT_W     = $clog2(DATA_W);

  logic wr;
  assign wr = bus_valid & bus_write;

  always_comb begin
    db_set = '0;
    if (wr && bus_addr == ADDR_W'(DOORBELL_OFS) &&
        bus_wdata >= DATA_W'(NUM_WIRED) && bus_wdata < DATA_W'(NUM_SRC))
      db_set[bus_wdata[IDX_W-1:0]] = 1'b1;
  end

  always_comb begin
    ack_clr = '0;
    mask_we = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wr && bus_addr == ADDR_W'(CAUSE_BASE + WORD_STRIDE * w) &&
          bus_wdata < DATA_W'(DATA_W))
        ack_clr[w * DATA_W + int'(bus_wdata[BIT_W-1:0])] = 1'b1;
      if (wr && bus_addr == ADDR_W'(MASK_BASE + WORD_STRIDE * w))
        mask_we[w] = 1'b1;
    end
  end

  // R5: an acknowledge clears at most one source
  assert_single_ack_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_clr));
  // R3: a doorbell write raises at most one source
  assert_single_doorbell_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(db_set));
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int NUM_SRC   = 64,
  parameter int NUM_WIRED = 21,
  parameter int DATA_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_WIRED-1:0]      wired_set,
  input  logic [NUM_SRC-1:0]        db_set,
  input  logic [NUM_SRC-1:0]        ack_clr,
  input  logic [NUM_SRC/DATA_W-1:0] mask_we,
  input  logic [DATA_W-1:0]         mask_wdata,
  output logic [NUM_SRC-1:0]        cause_o,
  output logic [NUM_SRC-1:0]        mask_o,
  output logic                      irq_o
);
  localparam int NUM_WORDS = NUM_SRC / DATA_W;

  logic [NUM_SRC-1:0] cause_q, mask_q, set_vec;
  logic               irq_q;

  assign set_vec = db_set | {{(NUM_SRC-NUM_WIRED){1'b0}}, wired_set};

  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= (cause_q & ~ack_clr) | set_vec;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)             mask_q[w*DATA_W +: DATA_W] <= '1;
      else if (mask_we[w]) mask_q[w*DATA_W +: DATA_W] <= mask_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(cause_q & ~mask_q);
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign irq_o   = irq_q;

  // R1: state right after reset
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cause_q == '0) && (&mask_q) && !irq_q);
  // R8: any set request is visible next cycle regardless of clears
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cause_q & $past(set_vec)) == $past(set_vec));
  // R6: fully masked vector keeps the line low next cycle
  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |=> !irq_q);
endmodule

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int NUM_SRC   = 64,
  parameter int NUM_WIRED = 21,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WIRED-1:0] wired_i,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  output logic                 irq_o
);
  import irq_col_pkg::*;
  localparam int NUM_WORDS = NUM_SRC / DATA_W;

  logic [NUM_WIRED-1:0] wired_pulse;
  logic [NUM_SRC-1:0]   db_set, ack_clr, cause, mask;
  logic [NUM_WORDS-1:0] mask_we;
  logic [DATA_W-1:0]    rd_mux;

  irq_edge_detect #(.N(NUM_WIRED)) u_edge (
    .clk(clk), .rst(rst), .lvl_i(wired_i), .pulse_o(wired_pulse)
  );

  irq_bus_decode #(
    .NUM_SRC(NUM_SRC), .NUM_WIRED(NUM_WIRED), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dec (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .db_set(db_set), .ack_clr(ack_clr), .mask_we(mask_we)
  );

  irq_cause_bank #(
    .NUM_SRC(NUM_SRC), .NUM_WIRED(NUM_WIRED), .DATA_W(DATA_W)
  ) u_bank (
    .clk(clk), .rst(rst), .wired_set(wired_pulse), .db_set(db_set),
    .ack_clr(ack_clr), .mask_we(mask_we), .mask_wdata(bus_wdata),
    .cause_o(cause), .mask_o(mask), .irq_o(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (bus_addr == ADDR_W'(CAUSE_BASE + WORD_STRIDE * w))
        rd_mux = cause[w*DATA_W +: DATA_W];
      if (bus_addr == ADDR_W'(MASK_BASE + WORD_STRIDE * w))
        rd_mux = mask[w*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_valid & ~bus_write;
      if (bus_valid & ~bus_write) bus_rdata <= rd_mux;
    end
  end

  // R4: read data is marked valid exactly one cycle after a read request
  assert_read_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> bus_rvalid);
  assert_no_spurious_rvalid_R4: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> !bus_rvalid);
endmodule

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [20:0] wired = '0;
  logic        valid = 1'b0, write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq;

  int total = 0, bad = 0;
  logic [63:0] exp_cause = '0, exp_mask = '1;

  always #5 clk = ~clk;

  irq_collector u_irq_collector (
    .clk(clk), .rst(rst), .wired_i(wired), .bus_valid(valid), .bus_write(write),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid),
    .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); valid = 1; write = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; write = 0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); valid = 1; write = 0; addr = a;
    @(negedge clk); valid = 0;
    chk("R4 rvalid", {31'b0, rvalid}, 32'd1);
    d = rdata;
  endtask

  task automatic chk_all(input string req);
    logic [31:0] v;
    br(8'h00, v); chk({req, " cause0"}, v, exp_cause[31:0]);
    br(8'h04, v); chk({req, " cause1"}, v, exp_cause[63:32]);
    br(8'h20, v); chk({req, " mask0"},  v, exp_mask[31:0]);
    br(8'h24, v); chk({req, " mask1"},  v, exp_mask[63:32]);
  endtask

  task automatic raise(input int i);
    if (i < 21) begin
      @(negedge clk); wired[i] = 1'b1;
      @(negedge clk); wired[i] = 1'b0;
    end else bw(8'h30, 32'(i));
    exp_cause[i] = 1'b1;
  endtask

  task automatic ack(input int i);
    bw(8'(4 * (i / 32)), 32'(i % 32));
    exp_cause[i] = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 0);
    chk_all("R1");

    // R9: undefined reads and writes
    foreach (v[k]) ;
    br(8'h08, v); chk("R9 rd 08", v, 0);
    br(8'h28, v); chk("R9 rd 28", v, 0);
    br(8'h30, v); chk("R9 rd 30", v, 0);
    br(8'h01, v); chk("R9 rd 01", v, 0);
    br(8'h21, v); chk("R9 rd 21", v, 0);
    bw(8'h08, '1); bw(8'h2C, '1); bw(8'h31, 32'd30); bw(8'h22, 32'd0);
    chk_all("R9 wr");

    // R3/R5: doorbell sweep over all small values plus high-bit aliases
    for (int d = 0; d < 72; d++) begin
      bw(8'h30, 32'(d));
      if (d >= 21 && d < 64) exp_cause[d] = 1'b1;
      chk_all("R3 doorbell");
      if (d >= 21 && d < 64) begin
        ack(d);
        chk_all("R5 ack");
      end
      chk("R7 masked irq", {31'b0, irq}, 0);
    end
    bw(8'h30, 32'h0000_0115); chk_all("R3 alias");
    bw(8'h30, 32'hFFFF_FF16); chk_all("R3 alias hi");

    // R2: wired rising edge, hold-high, no re-set after acknowledge
    for (int i = 0; i < 21; i++) begin
      @(negedge clk); wired[i] = 1'b1;
      exp_cause[i] = 1'b1;
      chk_all("R2 edge");
      ack(i);
      repeat (3) @(negedge clk);
      chk_all("R2 held");
      wired[i] = 1'b0;
    end

    // R5: acknowledge value >= 32 is ignored, wrong word leaves bit alone
    raise(40);
    bw(8'h04, 32'd40); chk_all("R5 big index");
    bw(8'h00, 32'd8);  chk_all("R5 wrong word");
    bw(8'h04, 32'd8);  exp_cause[40] = 0; chk_all("R5 word1");

    // R6/R7: per-source masking and irq latency
    bw(8'h20, 32'h0); bw(8'h24, 32'h0);
    exp_mask = '0;
    chk_all("R6 unmask");
    for (int i = 0; i < 64; i++) begin
      raise(i);
      chk("R7 latency", {31'b0, irq}, 0);
      @(negedge clk);
      chk("R7 raise", {31'b0, irq}, 1);
      bw(8'(32 + 4 * (i / 32)), 32'd1 << (i % 32));
      @(negedge clk);
      chk("R6 blocked", {31'b0, irq}, 0);
      bw(8'(32 + 4 * (i / 32)), 32'd0);
      @(negedge clk);
      chk("R6 enabled", {31'b0, irq}, 1);
      ack(i);
      @(negedge clk);
      chk("R5 irq cleared", {31'b0, irq}, 0);
    end
    chk_all("R5 all clear");

    // R8: rising edge and acknowledge of same bit in one cycle
    @(negedge clk);
    wired[5] = 1'b1; valid = 1; write = 1; addr = 8'h00; wdata = 32'd5;
    @(negedge clk); valid = 0; write = 0;
    exp_cause[5] = 1'b1;
    chk_all("R8 set wins");
    wired[5] = 1'b0;
    ack(5);
    chk_all("R8 cleanup");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule